// File: doc/BRIEF.md
# Dual-Plane Egress Path Selector

This block sits between two redundant switch planes, called X and Y, and the transmit output toward a processing element. Each plane has its own egress buffer. The selector follows one in-service status input per plane and picks the active plane. It opens writes only into the active plane's egress buffer and drives a stop control into each buffer. It passes the active buffer's word stream to the output.

A plane change takes effect only between packets. A packet is a fixed number of words, 20 by default, which is 80 bytes at 32 bits per word. The block counts the words it forwards. If the status inputs ask for the other plane in the middle of a packet, the change waits until the last word of that packet has gone out. Packets lost or repeated across a switchover are passed on as they come. The block does not reorder, drop or regenerate any of them.

Top module: `plane_path_select`

## Requirements
- R1: After reset, plane X is selected, `x_wr_en`=1, `y_wr_en`=0, and the word count is at a packet boundary.
- R2: At a packet boundary, when exactly one in-service input is high and it names the other plane, the selection moves to that plane at the next clock edge. During that boundary cycle both stop outputs are 1 and `out_valid` is 0.
- R3: In the middle of a packet (forwarded-word count not zero), the selection never changes, whatever the in-service inputs do.
- R4: When both in-service inputs are high, the current selection is kept.
- R5: When neither in-service input is high, the selection is kept, both stop outputs are 1, `out_valid` is 0, and the word count does not move.
- R6: Exactly one of `x_wr_en`/`y_wr_en` is 1, and it names the selected plane (`y_wr_en`=1 means Y is selected).
- R7: The stop output of the unselected plane is always 1. The stop output of the selected plane is 0 exactly when at least one in-service input is high and no switch is waiting at a boundary.
- R8: `out_valid` is 1 exactly when the selected plane's `*_rd_valid` is 1 and its stop output is 0. `out_data` then equals that plane's `*_rd_data`. A word from the unselected plane never reaches the output.
- R9: The word count advances on each forwarded word and returns to the boundary after PKT_WORDS words. A waiting switch is applied only after the PKT_WORDS-th word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| x_in_svc | input | 1 | Plane X in service |
| y_in_svc | input | 1 | Plane Y in service |
| x_rd_valid | input | 1 | X egress buffer has a word ready |
| x_rd_data | input | DATA_W | X egress buffer head word |
| y_rd_valid | input | 1 | Y egress buffer has a word ready |
| y_rd_data | input | DATA_W | Y egress buffer head word |
| x_wr_en | output | 1 | Write enable into X egress buffer |
| y_wr_en | output | 1 | Write enable into Y egress buffer |
| x_stop | output | 1 | Halts X egress buffer read flow |
| y_stop | output | 1 | Halts Y egress buffer read flow |
| out_valid | output | 1 | Output word valid (a word was taken from the selected buffer) |
| out_data | output | DATA_W | Output word |

## Verification
The checker watches every cycle for the following rules. The selection stays still while a packet is in progress. The write enables stay one-hot. The unselected buffer stays stopped. No output word appears with both planes out of service or without a ready word on the selected plane. The word count stays inside the packet length. Only the bench's scenarios show when things happen: that a waiting switch lands exactly after the final word of a packet, that data comes from the right plane, and that selection is held while both planes are in service. For this the bench sweeps every combination of status and ready inputs over varied hold lengths against an arithmetic model of the packet count.

// File: rtl/plane_path_pkg.sv
package plane_path_pkg;
   typedef enum logic {
      PLANE_X = 1'b0,
      PLANE_Y = 1'b1
   } plane_e;
endpackage

// File: rtl/plane_sel_fsm.sv
module plane_sel_fsm
   import plane_path_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   x_in_svc,
   input  logic   y_in_svc,
   input  logic   at_boundary,
   output plane_e sel,
   output logic   switch_now,
   output logic   run
);
   plane_e sel_q;
   plane_e want;
   logic   any_svc;

   always_comb begin
      any_svc = x_in_svc | y_in_svc;
      if (x_in_svc && !y_in_svc)      want = PLANE_X;
      else if (y_in_svc && !x_in_svc) want = PLANE_Y;
      else                            want = sel_q;
      switch_now = at_boundary && (want != sel_q);
      run        = any_svc && !switch_now;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          sel_q <= PLANE_X;
      else if (switch_now) sel_q <= want;
   end

   assign sel = sel_q;
endmodule

// File: rtl/pkt_word_counter.sv
module pkt_word_counter #(
   parameter int PKT_WORDS = 20,
   localparam int CNT_W = (PKT_WORDS > 1) ? $clog2(PKT_WORDS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   output logic [CNT_W-1:0] count,
   output logic             at_boundary
);
   generate
      if (PKT_WORDS == 1) begin : g_single
         assign count       = '0;
         assign at_boundary = 1'b1;
      end else begin : g_multi
         localparam logic [CNT_W-1:0] LAST = CNT_W'(PKT_WORDS - 1);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (advance)
               cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end
         assign count       = cnt_q;
         assign at_boundary = (cnt_q == '0);
      end
   endgenerate
endmodule

// File: rtl/plane_data_mux.sv
module plane_data_mux
   import plane_path_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  plane_e              sel,
   input  logic                run,
   input  logic [1:0]          rd_valid,
   input  logic [1:0][DATA_W-1:0] rd_data,
   output logic [1:0]          wr_en,
   output logic [1:0]          stop,
   output logic                pop,
   output logic [DATA_W-1:0]   data
);
   generate
      for (genvar p = 0; p < 2; p++) begin : g_plane
         logic mine;
         assign mine     = (sel == plane_e'(p));
         assign wr_en[p] = mine;
         assign stop[p]  = !(mine && run);
      end
   endgenerate

   always_comb begin
      pop  = rd_valid[sel] && !stop[sel];
      data = rd_data[sel];
   end
endmodule

// File: rtl/plane_path_select.sv
module plane_path_select
   import plane_path_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int PKT_WORDS = 20,
   localparam int CNT_W    = (PKT_WORDS > 1) ? $clog2(PKT_WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              x_in_svc,
   input  logic              y_in_svc,
   input  logic              x_rd_valid,
   input  logic [DATA_W-1:0] x_rd_data,
   input  logic              y_rd_valid,
   input  logic [DATA_W-1:0] y_rd_data,
   output logic              x_wr_en,
   output logic              y_wr_en,
   output logic              x_stop,
   output logic              y_stop,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("plane_path_select: DATA_W must be at least 1");
      end
      if (PKT_WORDS < 1) begin : g_bad_pkt
         $error("plane_path_select: PKT_WORDS must be at least 1");
      end
   endgenerate

   plane_e                  sel;
   logic                    switch_now;
   logic                    run;
   logic                    at_boundary;
   logic [CNT_W-1:0]        pkt_cnt;
   logic                    pop;
   logic [1:0]              wr_en_v;
   logic [1:0]              stop_v;
   logic [1:0][DATA_W-1:0]  rd_data_v;

   assign rd_data_v[0] = x_rd_data;
   assign rd_data_v[1] = y_rd_data;

   plane_sel_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .x_in_svc    (x_in_svc),
      .y_in_svc    (y_in_svc),
      .at_boundary (at_boundary),
      .sel         (sel),
      .switch_now  (switch_now),
      .run         (run)
   );

   pkt_word_counter #(.PKT_WORDS(PKT_WORDS)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .advance     (pop),
      .count       (pkt_cnt),
      .at_boundary (at_boundary)
   );

   plane_data_mux #(.DATA_W(DATA_W)) u_mux (
      .sel      (sel),
      .run      (run),
      .rd_valid ({y_rd_valid, x_rd_valid}),
      .rd_data  (rd_data_v),
      .wr_en    (wr_en_v),
      .stop     (stop_v),
      .pop      (pop),
      .data     (out_data)
   );

   assign x_wr_en   = wr_en_v[0];
   assign y_wr_en   = wr_en_v[1];
   assign x_stop    = stop_v[0];
   assign y_stop    = stop_v[1];
   assign out_valid = pop;
endmodule

// File: rtl/plane_path_select_chk.sv
module plane_path_select_chk #(
   parameter int PKT_WORDS = 20,
   parameter int CNT_W     = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             x_in_svc,
   input logic             y_in_svc,
   input logic             x_rd_valid,
   input logic             y_rd_valid,
   input logic             x_wr_en,
   input logic             y_wr_en,
   input logic             x_stop,
   input logic             y_stop,
   input logic             out_valid,
   input logic             sel_y,
   input logic [CNT_W-1:0] pkt_cnt
);
   // R3: selection frozen while a packet is in progress
   a_r3_no_midpacket_switch: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_cnt != '0) |=> $stable(sel_y));

   // R6: write enables one-hot
   a_r6_wr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({x_wr_en, y_wr_en}) == 1);

   // R7: unselected buffer always stopped
   a_r7_unsel_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!x_wr_en |-> x_stop) and (!y_wr_en |-> y_stop));

   // R5: no output with both planes out of service
   a_r5_idle_no_output: assert property (@(posedge clk) disable iff (!rst_n)
      (!x_in_svc && !y_in_svc) |-> (!out_valid && x_stop && y_stop));

   // R8: an output word needs a ready word on the selected plane
   a_r8_valid_has_source: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (x_wr_en ? x_rd_valid : y_rd_valid));

   // R9: count stays inside the packet
   a_r9_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(pkt_cnt) < PKT_WORDS);

   // R4: both in service keeps the selection
   a_r4_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (x_in_svc && y_in_svc) |=> $stable(sel_y));
endmodule

bind plane_path_select plane_path_select_chk #(
   .PKT_WORDS (PKT_WORDS),
   .CNT_W     (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .x_in_svc   (x_in_svc),
   .y_in_svc   (y_in_svc),
   .x_rd_valid (x_rd_valid),
   .y_rd_valid (y_rd_valid),
   .x_wr_en    (x_wr_en),
   .y_wr_en    (y_wr_en),
   .x_stop     (x_stop),
   .y_stop     (y_stop),
   .out_valid  (out_valid),
   .sel_y      (sel == plane_path_pkg::PLANE_Y),
   .pkt_cnt    (pkt_cnt)
);

// File: tb/test_plane_path_select.sv
module test_plane_path_select;
   localparam int DW  = 32;
   localparam int PKT = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          x_in_svc = 1'b0, y_in_svc = 1'b0;
   logic          x_rd_valid = 1'b0, y_rd_valid = 1'b0;
   logic [DW-1:0] x_rd_data = '0, y_rd_data = '0;
   logic          x_wr_en, y_wr_en, x_stop, y_stop, out_valid;
   logic [DW-1:0] out_data;

   int vectors = 0;
   int errors  = 0;
   bit done    = 0;

   int m_sel = 0;   // 0 = X, 1 = Y
   int m_cnt = 0;
   logic [31:0] lfsr = 32'h1ACE_B00C;

   always #5 clk = ~clk;

   plane_path_select #(.DATA_W(DW), .PKT_WORDS(PKT)) i_plane_path_select (
      .clk, .rst_n, .x_in_svc, .y_in_svc,
      .x_rd_valid, .x_rd_data, .y_rd_valid, .y_rd_data,
      .x_wr_en, .y_wr_en, .x_stop, .y_stop, .out_valid, .out_data
   );

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] nxt(input logic [31:0] v);
      return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
   endfunction

   // drive one cycle, check, advance the model
   task automatic step(input logic xs, input logic ys, input logic xv, input logic yv);
      int  want;
      bit  sw, run, pop, selv;
      logic [DW-1:0] sd;
      @(negedge clk);
      x_in_svc = xs; y_in_svc = ys; x_rd_valid = xv; y_rd_valid = yv;
      lfsr = nxt(lfsr); x_rd_data = lfsr;
      lfsr = nxt(lfsr); y_rd_data = lfsr;
      #1;
      if (xs && !ys)      want = 0;
      else if (ys && !xs) want = 1;
      else                want = m_sel;
      sw   = (m_cnt == 0) && (want != m_sel);
      run  = (xs || ys) && !sw;
      selv = (m_sel == 1) ? yv : xv;
      pop  = selv && run;
      sd   = (m_sel == 1) ? y_rd_data : x_rd_data;
      chk("R6 x_wr_en", DW'(x_wr_en), DW'(m_sel == 0));
      chk("R6 y_wr_en", DW'(y_wr_en), DW'(m_sel == 1));
      chk("R7 x_stop",  DW'(x_stop),  DW'(!(m_sel == 0 && run)));
      chk("R7 y_stop",  DW'(y_stop),  DW'(!(m_sel == 1 && run)));
      chk("R8 out_valid", DW'(out_valid), DW'(pop));
      if (pop) chk("R8 out_data", out_data, sd);
      if (sw)       m_sel = want;
      else if (pop) m_cnt = (m_cnt + 1) % PKT;
   endtask

   initial begin
      #1_500_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      chk("R1 x_wr_en", DW'(x_wr_en), 1);
      chk("R1 y_wr_en", DW'(y_wr_en), 0);
      m_sel = 0; m_cnt = 0;

      // R3 / R9: ask for Y after 5 words of an X packet; switch must wait for word 20
      for (int i = 0; i < 5; i++) step(1, 0, 1, 0);
      for (int i = 0; i < 14; i++) step(0, 1, 1, 1);
      chk("R3 still X after 19 words", DW'(x_wr_en), 1);
      step(0, 1, 1, 1);                 // 20th word leaves from X
      chk("R9 20th word from X", DW'(x_stop), 0);
      step(0, 1, 1, 1);                 // boundary, switch cycle
      chk("R2 switch cycle no output", DW'(out_valid), 0);
      step(0, 1, 1, 1);
      chk("R2 now Y", DW'(y_wr_en), 1);

      // R4: both in service mid and at boundary holds Y
      for (int i = 0; i < 45; i++) step(1, 1, 1, 1);
      chk("R4 held Y", DW'(y_wr_en), 1);

      // R5: neither in service: no output, count frozen
      for (int i = 0; i < 10; i++) step(0, 0, 1, 1);
      chk("R5 no output", DW'(out_valid), 0);
      chk("R5 held Y", DW'(y_wr_en), 1);

      // near-exhaustive sweep: every input combo, hold lengths 1..25
      for (int len = 1; len <= 25; len++)
         for (int c = 0; c < 16; c++)
            for (int k = 0; k < len; k++)
               step(c[3], c[2], c[1] | k[0], c[0] | k[1]);

      // pseudo-random tail
      for (int i = 0; i < 4000; i++) begin
         lfsr = nxt(lfsr);
         step(lfsr[3] | lfsr[7], lfsr[5] | lfsr[9], lfsr[11] | lfsr[12], lfsr[13] | lfsr[14]);
      end

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule